// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard controller of a small out-of-order machine with five execution units: one integer unit, one floating-point adder, two floating-point multipliers and one floating-point divider. It accepts a decoded instruction stream one instruction at a time. It keeps a status record for every unit and a producer tag for every architectural register. Each instruction moves through four stages: issue, operand read, execution and result write. The controller grants each stage only when the hazards that stage must respect have cleared.

Execution is modelled as a fixed-latency countdown per unit, and each latency is a parameter. There is no result forwarding. A consumer takes its operands from the register file only after the producer's write has completed. The grant outputs tell the surrounding datapath when to accept an instruction, when a unit may latch its operands and when a unit may drive its result into the register file.

Top module: `sb_hazard_unit`

## Requirements
- R1: Instructions issue strictly in program order, at most one per cycle. `issueGrant` high means the instruction presented in that cycle is accepted. A stalled instruction holds back every later one.
- R2: Class codes on `instClass` are 0 integer, 1 add, 2 multiply and 3 divide. The one-hot bit order of `issueUnitOh`, `readGrant` and `writeGrant` is integer 0, adder 1, multiplier A 2, multiplier B 3, divider 4. Issue stalls while the required unit is busy. A multiply goes to multiplier A when it is free and otherwise to multiplier B.
- R3: Issue stalls while the destination register is still awaiting a result from an earlier instruction that has not written back. This includes an instruction that writes back in that same cycle.
- R4: A unit's operand read is granted once, and only when no source register awaits an in-flight producer. The earliest read is the cycle after the producer's write grant (no forwarding). The earliest read for any instruction is the cycle after its issue.
- R5: After an operand read in cycle c, the unit's write grant comes no earlier than cycle c+L+1. L is that unit's latency (defaults: integer 1, add 2, multiply 10, divide 40).
- R6: A finished result is not written while any other issued instruction still has to read the old value of that destination register.
- R7: A write grant frees the unit and clears the register's pending tag at the next edge. The unit can accept a new instruction from the following cycle on.
- R8: After reset, no grant is asserted, every unit is idle and no register is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is presented |
| instClass | input | 2 | Operation class (0 int, 1 add, 2 mul, 3 div) |
| instDst | input | $clog2(NUM_REGS) | Destination register |
| instSrc1 | input | $clog2(NUM_REGS) | First source register |
| instSrc2 | input | $clog2(NUM_REGS) | Second source register |
| issueGrant | output | 1 | Presented instruction is accepted this cycle |
| issueUnitOh | output | 5 | One-hot unit receiving the issued instruction |
| readGrant | output | 5 | Per-unit operand read strobe |
| writeGrant | output | 5 | Per-unit result write strobe |

## Verification
The bound checker watches the following on every cycle:
- at most one issue per cycle, and never into a busy unit;
- an issued unit becomes busy at the next edge and a written unit becomes free;
- each unit reads its operands only once and only while busy;
- no write follows directly on a read.

Whether a stall is correct cannot be seen by those properties. RAW waits, WAW and structural stalls, WAR write holds and the multiplier choice only show up as exact grant timing. The bench's instruction-level reference model checks that timing on every cycle. It runs directed sequences, among them the classic WAR case of a divide feeding an add while a multiply overwrites the add's second source, and a long pseudo-random mix.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_UNITS = 5;
  localparam int UID_W     = 3;
  localparam logic [UID_W-1:0] UNIT_NONE = '1;

  localparam int U_INT  = 0;
  localparam int U_ADD  = 1;
  localparam int U_MULA = 2;
  localparam int U_MULB = 3;
  localparam int U_DIV  = 4;

  typedef enum logic [1:0] {CLS_INT, CLS_ADD, CLS_MUL, CLS_DIV} opClass_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAITOPS, ST_EXEC, ST_DONE} unitStage_e;

  typedef struct packed {
    logic [NUM_UNITS-1:0] issueOh;
    logic [NUM_UNITS-1:0] readOh;
    logic [NUM_UNITS-1:0] writeOh;
  } sbStrobe_t;

  function automatic logic tagHit(input logic [UID_W-1:0] tag, input logic [NUM_UNITS-1:0] oh);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (tag == UID_W'(i)) hit = oh[i];
    return hit;
  endfunction

  function automatic logic [UID_W-1:0] ohToTag(input logic [NUM_UNITS-1:0] oh);
    logic [UID_W-1:0] tag;
    tag = UNIT_NONE;
    for (int i = 0; i < NUM_UNITS; i++)
      if (oh[i]) tag = UID_W'(i);
    return tag;
  endfunction
endpackage

// File: rtl/sb_status.sv
module sb_status import sb_pkg::*; #(
  parameter int NUM_REGS = 16,
  parameter int LAT_INT  = 1,
  parameter int LAT_ADD  = 2,
  parameter int LAT_MUL  = 10,
  parameter int LAT_DIV  = 40,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int MAX_LAT = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL,
  localparam int CNT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sbStrobe_t        stb,
  input  logic [REG_W-1:0] instDst,
  input  logic [REG_W-1:0] instSrc1,
  input  logic [REG_W-1:0] instSrc2,
  output logic [NUM_UNITS-1:0] busyVec,
  output logic [NUM_UNITS-1:0] waitVec,
  output logic [NUM_UNITS-1:0] doneVec,
  output logic [NUM_UNITS-1:0] rjVec,
  output logic [NUM_UNITS-1:0] rkVec,
  output logic [REG_W-1:0]     fiArr [NUM_UNITS],
  output logic [REG_W-1:0]     fjArr [NUM_UNITS],
  output logic [REG_W-1:0]     fkArr [NUM_UNITS],
  output logic [NUM_REGS-1:0]  regPending
);
  function automatic int unitLat(input int u);
    case (u)
      U_INT:          return LAT_INT;
      U_ADD:          return LAT_ADD;
      U_MULA, U_MULB: return LAT_MUL;
      default:        return LAT_DIV;
    endcase
  endfunction

  unitStage_e       stage [NUM_UNITS];
  logic [UID_W-1:0] qjArr [NUM_UNITS];
  logic [UID_W-1:0] qkArr [NUM_UNITS];
  logic [CNT_W-1:0] cnt   [NUM_UNITS];
  logic [UID_W-1:0] regStat [NUM_REGS];

  logic [UID_W-1:0] tagSrc1, tagSrc2, issueTag;
  logic             src1Ready, src2Ready;

  always_comb begin
    tagSrc1   = regStat[instSrc1];
    tagSrc2   = regStat[instSrc2];
    src1Ready = (tagSrc1 == UNIT_NONE) || tagHit(tagSrc1, stb.writeOh);
    src2Ready = (tagSrc2 == UNIT_NONE) || tagHit(tagSrc2, stb.writeOh);
    issueTag  = ohToTag(stb.issueOh);
  end

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_flags
      assign busyVec[u] = (stage[u] != ST_IDLE);
      assign waitVec[u] = (stage[u] == ST_WAITOPS);
      assign doneVec[u] = (stage[u] == ST_DONE);
    end
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_regflag
      assign regPending[r] = (regStat[r] != UNIT_NONE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        stage[u] <= ST_IDLE;
        fiArr[u] <= '0; fjArr[u] <= '0; fkArr[u] <= '0;
        qjArr[u] <= UNIT_NONE; qkArr[u] <= UNIT_NONE;
        rjVec[u] <= 1'b0; rkVec[u] <= 1'b0;
        cnt[u]   <= '0;
      end
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (stb.issueOh[u]) begin
          stage[u] <= ST_WAITOPS;
          fiArr[u] <= instDst; fjArr[u] <= instSrc1; fkArr[u] <= instSrc2;
          qjArr[u] <= src1Ready ? UNIT_NONE : tagSrc1;
          qkArr[u] <= src2Ready ? UNIT_NONE : tagSrc2;
          rjVec[u] <= src1Ready;
          rkVec[u] <= src2Ready;
        end else begin
          case (stage[u])
            ST_WAITOPS: begin
              if (stb.readOh[u]) begin
                stage[u] <= ST_EXEC;
                cnt[u]   <= CNT_W'(unitLat(u));
                rjVec[u] <= 1'b0;
                rkVec[u] <= 1'b0;
              end else begin
                if (qjArr[u] != UNIT_NONE && tagHit(qjArr[u], stb.writeOh)) begin
                  rjVec[u] <= 1'b1; qjArr[u] <= UNIT_NONE;
                end
                if (qkArr[u] != UNIT_NONE && tagHit(qkArr[u], stb.writeOh)) begin
                  rkVec[u] <= 1'b1; qkArr[u] <= UNIT_NONE;
                end
              end
            end
            ST_EXEC: begin
              if (cnt[u] == CNT_W'(1)) stage[u] <= ST_DONE;
              cnt[u] <= cnt[u] - CNT_W'(1);
            end
            ST_DONE: if (stb.writeOh[u]) stage[u] <= ST_IDLE;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regStat[r] <= UNIT_NONE;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++)
        if (stb.writeOh[u]) regStat[fiArr[u]] <= UNIT_NONE;
      if (|stb.issueOh) regStat[instDst] <= issueTag;
    end
  end
endmodule

// File: rtl/sb_control.sv
module sb_control import sb_pkg::*; #(
  parameter int NUM_REGS = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                 instValid,
  input  logic [1:0]           instClass,
  input  logic [REG_W-1:0]     instDst,
  input  logic [NUM_UNITS-1:0] busyVec,
  input  logic [NUM_UNITS-1:0] waitVec,
  input  logic [NUM_UNITS-1:0] doneVec,
  input  logic [NUM_UNITS-1:0] rjVec,
  input  logic [NUM_UNITS-1:0] rkVec,
  input  logic [REG_W-1:0]     fiArr [NUM_UNITS],
  input  logic [REG_W-1:0]     fjArr [NUM_UNITS],
  input  logic [REG_W-1:0]     fkArr [NUM_UNITS],
  input  logic [NUM_REGS-1:0]  regPending,
  output sbStrobe_t            stb
);
  logic [NUM_UNITS-1:0] warBlock;

  always_comb begin
    warBlock = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      for (int f = 0; f < NUM_UNITS; f++)
        if (f != u && busyVec[f] &&
            ((rjVec[f] && fjArr[f] == fiArr[u]) || (rkVec[f] && fkArr[f] == fiArr[u])))
          warBlock[u] = 1'b1;
  end

  always_comb begin
    stb         = '0;
    stb.writeOh = doneVec & ~warBlock;
    stb.readOh  = waitVec & rjVec & rkVec;
    if (instValid && !regPending[instDst]) begin
      case (opClass_e'(instClass))
        CLS_INT: stb.issueOh[U_INT] = !busyVec[U_INT];
        CLS_ADD: stb.issueOh[U_ADD] = !busyVec[U_ADD];
        CLS_MUL: begin
          if (!busyVec[U_MULA])      stb.issueOh[U_MULA] = 1'b1;
          else if (!busyVec[U_MULB]) stb.issueOh[U_MULB] = 1'b1;
        end
        default: stb.issueOh[U_DIV] = !busyVec[U_DIV];
      endcase
    end
  end
endmodule

// File: rtl/sb_hazard_unit.sv
module sb_hazard_unit import sb_pkg::*; #(
  parameter int NUM_REGS = 16,
  parameter int LAT_INT  = 1,
  parameter int LAT_ADD  = 2,
  parameter int LAT_MUL  = 10,
  parameter int LAT_DIV  = 40,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [1:0]       instClass,
  input  logic [REG_W-1:0] instDst,
  input  logic [REG_W-1:0] instSrc1,
  input  logic [REG_W-1:0] instSrc2,
  output logic             issueGrant,
  output logic [4:0]       issueUnitOh,
  output logic [4:0]       readGrant,
  output logic [4:0]       writeGrant
);
  sbStrobe_t            stb;
  logic [NUM_UNITS-1:0] busyVec, waitVec, doneVec, rjVec, rkVec;
  logic [REG_W-1:0]     fiArr [NUM_UNITS];
  logic [REG_W-1:0]     fjArr [NUM_UNITS];
  logic [REG_W-1:0]     fkArr [NUM_UNITS];
  logic [NUM_REGS-1:0]  regPending;

  sb_control #(.NUM_REGS(NUM_REGS)) uCtrl (
    .instValid(instValid), .instClass(instClass), .instDst(instDst),
    .busyVec(busyVec), .waitVec(waitVec), .doneVec(doneVec),
    .rjVec(rjVec), .rkVec(rkVec), .fiArr(fiArr), .fjArr(fjArr), .fkArr(fkArr),
    .regPending(regPending), .stb(stb)
  );

  sb_status #(.NUM_REGS(NUM_REGS), .LAT_INT(LAT_INT), .LAT_ADD(LAT_ADD),
              .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)) uStat (
    .clk(clk), .rstN(rstN), .stb(stb),
    .instDst(instDst), .instSrc1(instSrc1), .instSrc2(instSrc2),
    .busyVec(busyVec), .waitVec(waitVec), .doneVec(doneVec),
    .rjVec(rjVec), .rkVec(rkVec), .fiArr(fiArr), .fjArr(fjArr), .fkArr(fkArr),
    .regPending(regPending)
  );

  assign issueUnitOh = stb.issueOh;
  assign issueGrant  = |stb.issueOh;
  assign readGrant   = stb.readOh;
  assign writeGrant  = stb.writeOh;
endmodule

// File: rtl/sb_hazard_checker.sv
module sb_hazard_checker (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] issueUnitOh,
  input logic [4:0] readGrant,
  input logic [4:0] writeGrant,
  input logic [4:0] busyVec
);
  assert_single_issue_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueUnitOh));

  assert_issue_free_unit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issueUnitOh & busyVec) == 5'd0);

  assert_issue_occupies_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|issueUnitOh) |=> ((busyVec & $past(issueUnitOh)) == $past(issueUnitOh)));

  assert_read_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (readGrant & ~busyVec) == 5'd0);

  assert_read_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|readGrant) |=> ((readGrant & $past(readGrant)) == 5'd0));

  assert_no_early_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|readGrant) |=> ((writeGrant & $past(readGrant)) == 5'd0));

  assert_write_frees_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|writeGrant) |=> ((busyVec & $past(writeGrant)) == 5'd0));
endmodule

bind sb_hazard_unit sb_hazard_checker uChk (
  .clk(clk), .rstN(rstN), .issueUnitOh(issueUnitOh),
  .readGrant(readGrant), .writeGrant(writeGrant), .busyVec(busyVec)
);

// File: tb/sim_sb_hazard_unit.sv
`timescale 1ns/1ps
module sim_sb_hazard_unit;
  localparam int NR = 16;
  localparam int MAXI = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [1:0] instClass = 2'd0;
  logic [3:0] instDst = 4'd0, instSrc1 = 4'd0, instSrc2 = 4'd0;
  logic issueGrant;
  logic [4:0] issueUnitOh, readGrant, writeGrant;

  always #5 clk = ~clk;

  sb_hazard_unit #(.NUM_REGS(NR)) u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .instDst(instDst), .instSrc1(instSrc1), .instSrc2(instSrc2),
    .issueGrant(issueGrant), .issueUnitOh(issueUnitOh),
    .readGrant(readGrant), .writeGrant(writeGrant)
  );

  int checks = 0, errors = 0;
  int lat [5] = '{1, 2, 10, 10, 40};
  // per-instruction model: st 0 queued, 1 waiting operands, 2 executing/finished, 3 retired
  int cls [MAXI], dst [MAXI], s1 [MAXI], s2 [MAXI];
  int st [MAXI], un [MAXI], p1 [MAXI], p2 [MAXI], rdc [MAXI];
  int n = 0, head = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic addInst(input int c, input int d, input int a, input int b);
    cls[n] = c; dst[n] = d; s1[n] = a; s2[n] = b;
    st[n] = 0; un[n] = -1; p1[n] = -1; p2[n] = -1; rdc[n] = 0;
    n++;
  endtask

  function automatic bit unitBusy(input int u);
    for (int j = 0; j < head; j++)
      if (un[j] == u && (st[j] == 1 || st[j] == 2)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit ready(input int p);
    return (p < 0) || (st[p] == 3);
  endfunction

  function automatic int producerOf(input int r);
    for (int j = head - 1; j >= 0; j--)
      if ((st[j] == 1 || st[j] == 2) && dst[j] == r) return j;
    return -1;
  endfunction

  task automatic stepCycle();
    int expIss, expRd, expWr, u;
    bit waw, blk;
    @(negedge clk);
    if (head < n) begin
      instValid = 1'b1; instClass = 2'(cls[head]);
      instDst = 4'(dst[head]); instSrc1 = 4'(s1[head]); instSrc2 = 4'(s2[head]);
    end else instValid = 1'b0;
    #1;
    expIss = 0; expRd = 0; expWr = 0; u = -1;
    if (head < n) begin
      waw = (producerOf(dst[head]) >= 0);
      case (cls[head])
        0: u = unitBusy(0) ? -1 : 0;
        1: u = unitBusy(1) ? -1 : 1;
        2: u = !unitBusy(2) ? 2 : (!unitBusy(3) ? 3 : -1);
        default: u = unitBusy(4) ? -1 : 4;
      endcase
      if (waw) u = -1;
      if (u >= 0) expIss = 1 << u;
    end
    for (int j = 0; j < head; j++) begin
      if (st[j] == 1 && cyc > rdc[j] && ready(p1[j]) && ready(p2[j])) expRd |= 1 << un[j];
      if (st[j] == 2 && cyc >= rdc[j] + lat[un[j]] + 1) begin
        blk = 1'b0;
        for (int k = 0; k < head; k++)
          if (k != j && st[k] == 1 &&
              ((s1[k] == dst[j] && ready(p1[k])) || (s2[k] == dst[j] && ready(p2[k]))))
            blk = 1'b1;
        if (!blk) expWr |= 1 << un[j];
      end
    end
    check(issueUnitOh == 5'(expIss) && issueGrant == (expIss != 0),
          "R1 R2 R3 issue", int'(issueUnitOh), expIss);
    check(readGrant == 5'(expRd), "R4 operand read", int'(readGrant), expRd);
    check(writeGrant == 5'(expWr), "R5 R6 R7 write", int'(writeGrant), expWr);
    for (int j = 0; j < head; j++) begin
      if (st[j] == 1 && ((expRd >> un[j]) & 1) != 0) begin st[j] = 2; rdc[j] = cyc; end
      else if (st[j] == 2 && ((expWr >> un[j]) & 1) != 0) st[j] = 3;
    end
    if (expIss != 0) begin
      un[head] = u; st[head] = 1; rdc[head] = cyc;
      p1[head] = producerOf(s1[head]); p2[head] = producerOf(s2[head]);
      // producerOf skips the new entry since head not yet advanced
      head++;
    end
    cyc++;
  endtask

  task automatic runAll(input string name);
    int guard = 0;
    bit busy = 1'b1;
    while (busy && guard < 20000) begin
      stepCycle();
      guard++;
      busy = (head < n);
      for (int j = 0; j < n; j++) if (st[j] != 3) busy = 1'b1;
    end
    check(!busy, {"watchdog R1 ", name}, int'(busy), 0);
    n = 0; head = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check(issueGrant == 1'b0 && readGrant == 5'd0 && writeGrant == 5'd0,
          "R8 reset idle", int'({issueGrant, readGrant, writeGrant}), 0);
    stepCycle();
    // RAW chain on the integer and add units, no forwarding
    addInst(0, 1, 2, 3); addInst(1, 4, 1, 1); addInst(0, 5, 4, 1);
    runAll("raw");
    // WAR: divide feeds add, multiply overwrites add's second source
    addInst(3, 0, 2, 4); addInst(1, 10, 0, 8); addInst(2, 8, 8, 14);
    runAll("war");
    // WAW and structural stalls, second multiplier choice
    addInst(2, 1, 2, 3); addInst(2, 5, 6, 7); addInst(2, 9, 1, 5);
    addInst(1, 1, 3, 3); addInst(0, 7, 7, 7);
    runAll("waw_struct");
    // pseudo-random mix over eight registers
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      int c, d, a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c = (lfsr[2:0] == 3'd7) ? 3 : int'(lfsr[1:0] == 2'd3 ? 2'd2 : lfsr[1:0]);
      d = int'(lfsr[5:3]); a = int'(lfsr[8:6]); b = int'(lfsr[11:9]);
      addInst(c, d, a, b);
    end
    runAll("mix");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    errors++;
    $display("FAIL R1 watchdog expired actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule